// File: doc/BRIEF.md
# Priority Local-Bus Interrupt Controller

This block gathers sixteen level-sensitive interrupt request lines from local-bus devices into a source register that tracks the line levels, qualifies them with a software-writable enable mask, and drives one combined interrupt output towards the processor. Software reads a vector register to learn which pending, enabled source has the highest priority. Priority is fixed: the lowest line index wins.

The register port is 16 bits wide and addressed by a 12-bit byte offset. Two offsets are decoded. Offset 0x000 holds the read-only vector. Offset 0x002 holds the enable mask, which can be read and written. Every other offset reads as zero and ignores writes. Read data is registered and appears on the cycle after the read strobe.

The design has no edge detection, no nesting and no acknowledge cycle. An interrupt remains pending for as long as its line is held high.

Top module: `local_irq_ctrl`

## Requirements
- R1: Each source bit follows the level of its input line and is captured one clock after the line changes. It is set while the line is high and clears when the line goes low.
- R2: `irq_o` is a register. One clock after any change, it equals the OR over all bits of (captured source AND enable mask).
- R3: A read at offset 0x000 returns (i + 1) << 2, where i is the lowest index whose source bit and mask bit are both 1.
- R4: A read at offset 0x000 returns 0 when no source bit is both set and enabled. This includes the case where lines are high but masked off.
- R5: Offset 0x002 holds the 16-bit enable mask, with bit i enabling line i. A write there changes the mask and `irq_o` on the very next clock. A read there returns the current mask.
- R6: After synchronous reset, the mask is 0x0010, the source register is 0, `irq_o` is low and `reg_rdata` is 0.
- R7: A read at any offset other than 0x000 and 0x002 returns 0. A write to any offset other than 0x002, offset 0x000 included, changes neither the mask nor `irq_o`.
- R8: `reg_rdata` is loaded on the clock edge where `reg_rd_en` is high and holds its value while `reg_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 16 | Level-sensitive interrupt request lines |
| reg_addr | input | 12 | Register byte offset |
| reg_rd_en | input | 1 | Read strobe |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The bench builds the block with its default sixteen lines and 16-bit data. At that size, every single-line case can be walked under a full mask, and 8192 pseudo-random pairs of line pattern and mask can be compared against an arithmetic lowest-set-bit model. This covers the priority order at every position, masked-but-high lines, and the top index, whose vector is 0x40. Directed steps cover the reset values, the one-clock effect of a mask write on `irq_o`, stray writes and reads at undecoded offsets, and the holding of read data.

// File: rtl/lbic_pkg.sv
package lbic_pkg;

    localparam int LINE_CNT   = 16;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 12;
    localparam int VEC_SHIFT  = 2;

    localparam logic [ADDR_W-1:0] OFS_VECTOR = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h002;
    localparam logic [DATA_W-1:0] ENABLE_RST = 16'h0010;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_VECTOR = 2'd1,
        SEL_ENABLE = 2'd2
    } reg_sel_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    function automatic reg_sel_t decode_offset(input logic [ADDR_W-1:0] a);
        if (a == OFS_VECTOR)      return SEL_VECTOR;
        else if (a == OFS_ENABLE) return SEL_ENABLE;
        else                      return SEL_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] vector_code(input int idx);
        return DATA_W'((idx + 1) << VEC_SHIFT);
    endfunction

endpackage

// File: rtl/lbic_level_capture.sv
module lbic_level_capture
    import lbic_pkg::*;
#(
    parameter int N = LINE_CNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    output logic [N-1:0] src_q
);

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= lines;
    end

    a_r1_src_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> src_q == $past(lines));

endmodule

// File: rtl/lbic_mask_reg.sv
module lbic_mask_reg
    import lbic_pkg::*;
#(
    parameter int N = LINE_CNT
) (
    input  logic         clk,
    input  logic         rst,
    input  reg_req_t     req,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] mask_next
);

    logic hit;
    assign hit = req.wr && (decode_offset(req.addr) == SEL_ENABLE);

    always_comb begin
        mask_next = mask_q;
        if (hit) mask_next = req.wdata[N-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= ENABLE_RST[N-1:0];
        else     mask_q <= mask_next;
    end

    a_r6_mask_reset: assert property (@(posedge clk)
        rst |=> mask_q == ENABLE_RST[N-1:0]);

    a_r5_mask_write: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.addr == OFS_ENABLE) |=> mask_q == $past(req.wdata[N-1:0]));

    a_r7_mask_kept: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.addr == OFS_ENABLE) |=> $stable(mask_q));

endmodule

// File: rtl/lbic_prio_encoder.sv
module lbic_prio_encoder
    import lbic_pkg::*;
#(
    parameter int N = LINE_CNT,
    parameter int W = DATA_W
) (
    input  logic [N-1:0] pend,
    output logic [N-1:0] first,
    output logic [W-1:0] vector
);

    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign first[g]    = pend[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | pend[g];
    end

    always_comb begin
        vector = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) vector = vector | W'(vector_code(i));
        end
    end

endmodule

// File: rtl/local_irq_ctrl.sv
module local_irq_ctrl
    import lbic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_CNT-1:0] line_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd_en,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);

    reg_req_t              req;
    logic [LINE_CNT-1:0]   src_q;
    logic [LINE_CNT-1:0]   mask_q;
    logic [LINE_CNT-1:0]   mask_next;
    logic [LINE_CNT-1:0]   pend;
    logic [LINE_CNT-1:0]   first;
    logic [DATA_W-1:0]     vector;
    logic [DATA_W-1:0]     rd_mux;

    assign req = '{rd: reg_rd_en, wr: reg_wr_en, addr: reg_addr, wdata: reg_wdata};

    lbic_level_capture #(.N(LINE_CNT)) u_capture (
        .clk   (clk),
        .rst   (rst),
        .lines (line_in),
        .src_q (src_q)
    );

    lbic_mask_reg #(.N(LINE_CNT)) u_mask (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .mask_q    (mask_q),
        .mask_next (mask_next)
    );

    assign pend = src_q & mask_q;

    lbic_prio_encoder #(.N(LINE_CNT), .W(DATA_W)) u_enc (
        .pend   (pend),
        .first  (first),
        .vector (vector)
    );

    always_comb begin
        unique case (decode_offset(req.addr))
            SEL_VECTOR: rd_mux = vector;
            SEL_ENABLE: rd_mux = DATA_W'(mask_q);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
            irq_o     <= 1'b0;
        end else begin
            if (req.rd) reg_rdata <= rd_mux;
            irq_o <= |(line_in & mask_next);
        end
    end

    a_r2_irq_matches: assert property (@(posedge clk) disable iff (rst)
        irq_o == (|(src_q & mask_q)));

    a_r3_single_winner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(first) && ((|pend) == (|first)));

    a_r4_zero_vector: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && reg_addr == OFS_VECTOR && !irq_o) |=> reg_rdata == '0);

    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !reg_rd_en |=> $stable(reg_rdata));

    a_r6_reset_out: assert property (@(posedge clk)
        rst |=> (!irq_o && reg_rdata == '0 && src_q == '0));

endmodule

// File: tb/tb_local_irq_ctrl.sv
module tb_local_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] line_in;
    logic [11:0] reg_addr;
    logic        reg_rd_en;
    logic        reg_wr_en;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    local_irq_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .reg_addr  (reg_addr),
        .reg_rd_en (reg_rd_en),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    function automatic logic [15:0] exp_vec(input logic [15:0] p, input logic [15:0] m);
        logic [15:0] pm = p & m;
        for (int i = 0; i < 16; i++) if (pm[i]) return 16'((i + 1) << 2);
        return 16'h0000;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // Called at a negedge; drives inputs and returns at the next negedge.
    task automatic step(input logic [15:0] lines, input logic we, input logic re,
                        input logic [11:0] a, input logic [15:0] wd);
        line_in = lines; reg_wr_en = we; reg_rd_en = re; reg_addr = a; reg_wdata = wd;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] p, m, lfsr_a, lfsr_b;
        rst = 1; line_in = 0; reg_addr = 0; reg_rd_en = 0; reg_wr_en = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R6 reset state
        chk("R6 irq", {15'd0, irq_o}, 16'd0);
        chk("R6 rdata", reg_rdata, 16'd0);
        step(16'h0, 0, 1, 12'h002, 0);
        chk("R6 mask reset", reg_rdata, 16'h0010);
        step(16'h0, 0, 1, 12'h000, 0);
        chk("R6 source empty", reg_rdata, 16'h0000);

        // R4 lines high but masked off by reset mask
        step(16'hFFEF, 0, 0, 12'h000, 0);
        step(16'hFFEF, 0, 1, 12'h000, 0);
        chk("R4 masked vector", reg_rdata, 16'h0000);
        chk("R4 masked irq", {15'd0, irq_o}, 16'd0);

        // R3/R1 single lines under full mask
        step(16'h0, 1, 0, 12'h002, 16'hFFFF);
        for (int i = 0; i < 16; i++) begin
            step(16'(1 << i), 0, 0, 12'h000, 0);
            step(16'(1 << i), 0, 1, 12'h000, 0);
            chk($sformatf("R3 single line %0d", i), reg_rdata, 16'((i + 1) << 2));
            chk("R2 irq single", {15'd0, irq_o}, 16'd1);
        end
        // R1 line dropping clears source
        step(16'h0, 0, 0, 12'h000, 0);
        step(16'h0, 0, 1, 12'h000, 0);
        chk("R1 cleared source", reg_rdata, 16'h0000);
        chk("R1 irq after clear", {15'd0, irq_o}, 16'd0);

        // R3/R2/R4 sweep of line pattern and mask
        lfsr_a = 16'hACE1; lfsr_b = 16'h1D2B;
        for (int k = 0; k < 8192; k++) begin
            lfsr_a = {lfsr_a[14:0], lfsr_a[15] ^ lfsr_a[13] ^ lfsr_a[12] ^ lfsr_a[10]};
            lfsr_b = {lfsr_b[14:0], lfsr_b[15] ^ lfsr_b[13] ^ lfsr_b[12] ^ lfsr_b[10]};
            p = (k[0]) ? (lfsr_a & lfsr_b) : lfsr_a;
            m = (k[1]) ? ~lfsr_b : lfsr_b;
            step(p, 1, 0, 12'h002, m);
            step(p, 0, 1, 12'h000, 0);
            chk("R3 sweep vector", reg_rdata, exp_vec(p, m));
            chk("R2 sweep irq", {15'd0, irq_o}, {15'd0, |(p & m)});
        end

        // R5 mask write takes effect on the next clock
        step(16'h0100, 1, 0, 12'h002, 16'h0000);
        chk("R5 irq off", {15'd0, irq_o}, 16'd0);
        step(16'h0100, 1, 0, 12'h002, 16'h0100);
        chk("R5 irq on after write", {15'd0, irq_o}, 16'd1);
        step(16'h0100, 0, 1, 12'h002, 0);
        chk("R5 mask readback", reg_rdata, 16'h0100);

        // R7 stray writes ignored, stray reads zero
        step(16'h0100, 1, 0, 12'h004, 16'h0000);
        chk("R7 irq after stray write", {15'd0, irq_o}, 16'd1);
        step(16'h0100, 1, 0, 12'h000, 16'h0000);
        chk("R7 irq after vector write", {15'd0, irq_o}, 16'd1);
        step(16'h0100, 0, 1, 12'h002, 0);
        chk("R7 mask unchanged", reg_rdata, 16'h0100);
        step(16'h0100, 0, 1, 12'h006, 0);
        chk("R7 undefined read", reg_rdata, 16'h0000);
        step(16'h0100, 0, 1, 12'h001, 0);
        chk("R7 odd offset read", reg_rdata, 16'h0000);

        // R8 read data holds without a strobe
        step(16'h0100, 0, 1, 12'h000, 0);
        chk("R8 vector line 8", reg_rdata, 16'h0024);
        step(16'h0000, 0, 0, 12'h002, 0);
        step(16'h0000, 0, 0, 12'h000, 0);
        chk("R8 hold", reg_rdata, 16'h0024);

        // R6 reset mid-run restores mask
        rst = 1;
        step(16'hFFFF, 0, 0, 12'h000, 0);
        rst = 0;
        chk("R6 irq after reset", {15'd0, irq_o}, 16'd0);
        step(16'hFFFF, 0, 1, 12'h002, 0);
        chk("R6 mask after reset", reg_rdata, 16'h0010);
        step(16'hFFFF, 0, 1, 12'h000, 0);
        chk("R3 reset mask vector", reg_rdata, 16'h0014);

        finish_run();
    end

endmodule